// File: doc/BRIEF.md
# Pixel Hit Latency Buffer

This block is the digital back end of a single pixel readout cell. When the discriminator fires, the block does not push the hit down a delay line. It records the value present on a shared Gray-coded timestamp bus, which counts modulo n. From then on it measures the age of the hit by comparing that stored value with the live bus. A hit that is exactly as old as the programmed latency when the trigger strobe arrives is accepted. Every trigger writes one bit into a small per-pixel event memory: 1 if a waiting hit was accepted, 0 otherwise. This keeps the event slots of all pixels aligned.

Two independent hit holders let a second hit wait while the first is still pending. A hit that finds both holders occupied is lost and sets a sticky overflow flag. A holder is released when its hit is accepted, or when the hit grows older than the latency without a trigger. The event memory is four entries deep. Its write and read slots are chosen by 2-bit Gray-coded pointers supplied from the chip periphery.

Readout copies the selected entry into a one-bit output register. That register also acts as one stage of a serial chain running from pixel to pixel. Configuration registers hold a mask bit, a test-injection enable and a 3-bit threshold trim for the analog front end.

Top module: `pxl_hit_buffer`

## Requirements
- R1: An effective hit loads the current timestamp into holder 0 if it is free, otherwise into holder 1; one hit never occupies both holders.
- R2: A trigger sampled at the clock edge where a holder's age, (now − stored) mod n, equals `latency_i` writes 1 into the entry at the write pointer. A trigger at any other age, including one cycle early, writes 0 there.
- R3: A holder whose hit was accepted is free at the next edge, so two new hits fit without overflow.
- R4: A holder whose age exceeds `latency_i` without a trigger is freed, and a later trigger writes 0.
- R5: Two hits a few cycles apart are held at the same time and each is accepted by its own trigger.
- R6: An effective hit that arrives while both holders are busy is dropped and sets `ovf_o`; `ovf_o` then stays 1 until reset.
- R7: While the mask bit is set, neither `hit_i` nor `test_pulse_i` takes a holder, so a later trigger writes 0.
- R8: `test_pulse_i` acts as a hit only when the test-enable bit is set.
- R9: The mask, test-enable and `thadj_o` registers load only on an edge with `cfg_we_i` high; `thadj_o` shows the stored trim.
- R10: A pointer value g selects entry b, where b[1] = g[1] and b[0] = g[1] XOR g[0]. For example, Gray 11 selects entry 2 and Gray 10 selects entry 3.
- R11: With `ro_load_i` high, `ro_dout_o` takes the entry at the read pointer on the next edge. With only `ro_shift_i` high, it takes `ro_din_i`. Load wins over shift.
- R12: Age arithmetic is correct when the timestamp wraps from n−1 to 0 while a hit is waiting.
- R13: After reset, both holders are free, all entries are 0, `ovf_o` is 0, the configuration is 0 and `ro_dout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Discriminator hit, one cycle per hit |
| test_pulse_i | input | 1 | Test injection pulse |
| ts_gray_i | input | TS_W | Shared Gray-coded timestamp, modulo TS_MOD |
| latency_i | input | TS_W | Trigger latency in timestamp ticks |
| trig_i | input | 1 | Trigger strobe; writes one event entry |
| wr_ptr_gray_i | input | PTR_W | Gray-coded event write pointer |
| rd_ptr_gray_i | input | PTR_W | Gray-coded event read pointer |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_mask_i | input | 1 | Mask value to load |
| cfg_test_en_i | input | 1 | Test enable value to load |
| cfg_thadj_i | input | 3 | Threshold trim value to load |
| thadj_o | output | 3 | Stored threshold trim |
| ovf_o | output | 1 | Sticky holder overflow flag |
| ro_load_i | input | 1 | Load the addressed entry into the readout register |
| ro_shift_i | input | 1 | Shift the serial chain by one |
| ro_din_i | input | 1 | Serial input from the upstream pixel |
| ro_dout_o | output | 1 | Serial output / readout register |

## Verification
The holder checks assume that the timestamp bus advances by exactly one count per clock and that `latency_i` stays constant while hits are pending. They also assume `latency_i` is below n−1, so an expired hit is seen as older than the latency before its age wraps. The stimulus respects all three. A free-running modulo-n counter drives the bus. The latency is fixed at 20 with n = 200. Every scenario waits for all holders to drain before the next scenario begins, and one scenario deliberately places a hit a few ticks before the wrap.

// File: rtl/pxl_hit_pkg.sv
package pxl_hit_pkg;
  localparam int THADJ_W = 3;

  typedef struct packed {
    logic               mask;
    logic               test_en;
    logic [THADJ_W-1:0] thadj;
  } pxl_cfg_t;
endpackage

// File: rtl/pxl_gray_dec.sv
module pxl_gray_dec #(
  parameter int W = 8
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  assign bin_o[W-1] = gray_i[W-1];
  generate
    for (genvar i = W - 2; i >= 0; i--) begin : g_bit
      assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
  endgenerate
endmodule

// File: rtl/pxl_cfg_latch.sv
module pxl_cfg_latch
  import pxl_hit_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we_i,
  input  pxl_cfg_t cfg_d_i,
  output pxl_cfg_t cfg_q_o
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q_o <= '0;
    else if (we_i) cfg_q_o <= cfg_d_i;
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(cfg_q_o));
endmodule

// File: rtl/pxl_delay_unit.sv
module pxl_delay_unit #(
  parameter int TS_W   = 8,
  parameter int TS_MOD = 200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] ts_gray_i,
  input  logic [TS_W-1:0] ts_now_bin_i,
  input  logic [TS_W-1:0] latency_i,
  input  logic            capture_i,
  input  logic            trig_i,
  output logic            busy_o,
  output logic            match_o
);
  localparam logic [TS_W:0] MOD_X = TS_MOD[TS_W:0];

  logic [TS_W-1:0] ts_q, st_bin;
  logic [TS_W:0]   now_x, st_x, age;
  logic            expired;

  pxl_gray_dec #(.W(TS_W)) u_dec (.gray_i(ts_q), .bin_o(st_bin));

  always_comb begin
    now_x   = {1'b0, ts_now_bin_i};
    st_x    = {1'b0, st_bin};
    age     = (now_x >= st_x) ? (now_x - st_x) : (now_x + MOD_X - st_x);
    match_o = busy_o && trig_i && (age == {1'b0, latency_i});
    expired = busy_o && (age > {1'b0, latency_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ts_q   <= '0;
    end else if (capture_i) begin
      busy_o <= 1'b1;
      ts_q   <= ts_gray_i;
    end else if (match_o || expired) begin
      busy_o <= 1'b0;
    end
  end

  // R1
  capture_only_free_chk: assert property (@(posedge clk) disable iff (rst)
    capture_i |-> !busy_o);
  // R3
  match_release_chk: assert property (@(posedge clk) disable iff (rst)
    (match_o && !capture_i) |=> !busy_o);
  // R4
  expire_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !capture_i && (age > {1'b0, latency_i})) |=> !busy_o);
endmodule

// File: rtl/pxl_event_fifo.sv
module pxl_event_fifo #(
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_gray_i,
  input  logic             wr_bit_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] rd_ptr_gray_i,
  input  logic             shift_i,
  input  logic             din_i,
  output logic             dout_o
);
  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  pxl_gray_dec #(.W(PTR_W)) u_wdec (.gray_i(wr_ptr_gray_i), .bin_o(wr_addr));
  pxl_gray_dec #(.W(PTR_W)) u_rdec (.gray_i(rd_ptr_gray_i), .bin_o(rd_addr));

  always_ff @(posedge clk) begin
    if (rst)          mem_q <= '0;
    else if (wr_en_i) mem_q[wr_addr] <= wr_bit_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          dout_o <= 1'b0;
    else if (load_i)  dout_o <= mem_q[rd_addr];
    else if (shift_i) dout_o <= din_i;
  end

  // R11
  shift_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |=> (dout_o == $past(din_i)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !load_i) |=> $stable(dout_o));
endmodule

// File: rtl/pxl_hit_buffer.sv
module pxl_hit_buffer
  import pxl_hit_pkg::*;
#(
  parameter int TS_W       = 8,
  parameter int TS_MOD     = 200,
  parameter int NUM_UNITS  = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,
  input  logic               test_pulse_i,
  input  logic [TS_W-1:0]    ts_gray_i,
  input  logic [TS_W-1:0]    latency_i,
  input  logic               trig_i,
  input  logic [PTR_W-1:0]   wr_ptr_gray_i,
  input  logic [PTR_W-1:0]   rd_ptr_gray_i,
  input  logic               cfg_we_i,
  input  logic               cfg_mask_i,
  input  logic               cfg_test_en_i,
  input  logic [THADJ_W-1:0] cfg_thadj_i,
  output logic [THADJ_W-1:0] thadj_o,
  output logic               ovf_o,
  input  logic               ro_load_i,
  input  logic               ro_shift_i,
  input  logic               ro_din_i,
  output logic               ro_dout_o
);
  pxl_cfg_t              cfg_d, cfg_q;
  logic [TS_W-1:0]       ts_bin;
  logic [NUM_UNITS-1:0]  busy, cap, match;
  logic                  eff_hit, drop;

  assign cfg_d = '{mask: cfg_mask_i, test_en: cfg_test_en_i, thadj: cfg_thadj_i};

  pxl_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .cfg_d_i(cfg_d), .cfg_q_o(cfg_q)
  );
  assign thadj_o = cfg_q.thadj;

  pxl_gray_dec #(.W(TS_W)) u_tsdec (.gray_i(ts_gray_i), .bin_o(ts_bin));

  assign eff_hit = !cfg_q.mask && (hit_i || (cfg_q.test_en && test_pulse_i));

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      cap[i] = eff_hit && !busy[i] && !taken;
      taken  = taken || !busy[i];
    end
    drop = eff_hit && (&busy);
  end

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      pxl_delay_unit #(.TS_W(TS_W), .TS_MOD(TS_MOD)) u_dly (
        .clk(clk), .rst(rst), .ts_gray_i(ts_gray_i), .ts_now_bin_i(ts_bin),
        .latency_i(latency_i), .capture_i(cap[u]), .trig_i(trig_i),
        .busy_o(busy[u]), .match_o(match[u])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       ovf_o <= 1'b0;
    else if (drop) ovf_o <= 1'b1;
  end

  pxl_event_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en_i(trig_i), .wr_ptr_gray_i(wr_ptr_gray_i),
    .wr_bit_i(|match), .load_i(ro_load_i), .rd_ptr_gray_i(rd_ptr_gray_i),
    .shift_i(ro_shift_i), .din_i(ro_din_i), .dout_o(ro_dout_o)
  );

  // R6
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_hit && (&busy)) |=> ovf_o);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  // R7
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q.mask |=> ($countones(busy) <= $countones($past(busy))));
  // R1
  single_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !eff_hit |=> ($countones(busy) <= $countones($past(busy))));
endmodule

// File: tb/pxl_hit_buffer_tb.sv
module pxl_hit_buffer_tb;
  localparam int N = 200;
  localparam int L = 20;

  logic       clk = 1'b0, rst = 1'b1;
  logic       hit = 1'b0, tpulse = 1'b0, trig = 1'b0;
  logic [7:0] ts_b = '0, ts_gray;
  logic [1:0] wr_g = '0, rd_g = '0;
  logic       cfg_we = 1'b0, cfg_mask = 1'b0, cfg_ten = 1'b0;
  logic [2:0] cfg_th = '0, thadj;
  logic       ovf, ro_load = 1'b0, ro_shift = 1'b0, ro_din = 1'b0, ro_dout;

  int total = 0, bad = 0, cycles = 0;
  bit model [4] = '{0, 0, 0, 0};

  typedef struct { int val; string req; } exp_t;
  exp_t sb_q[$];
  logic take = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ts_b <= '0;
    else     ts_b <= (ts_b == N - 1) ? 8'd0 : ts_b + 8'd1;
  end
  assign ts_gray = ts_b ^ (ts_b >> 1);

  pxl_hit_buffer u_dut (
    .clk(clk), .rst(rst), .hit_i(hit), .test_pulse_i(tpulse),
    .ts_gray_i(ts_gray), .latency_i(8'(L)), .trig_i(trig),
    .wr_ptr_gray_i(wr_g), .rd_ptr_gray_i(rd_g), .cfg_we_i(cfg_we),
    .cfg_mask_i(cfg_mask), .cfg_test_en_i(cfg_ten), .cfg_thadj_i(cfg_th),
    .thadj_o(thadj), .ovf_o(ovf), .ro_load_i(ro_load), .ro_shift_i(ro_shift),
    .ro_din_i(ro_din), .ro_dout_o(ro_dout)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) take <= ro_load | ro_shift;
  always @(negedge clk) begin
    if (take) begin
      if (sb_q.size() == 0) chk("SB_EMPTY", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, int'(ro_dout), e.val);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] b2g(input int a);
    return 2'(a ^ (a >> 1));
  endfunction

  task automatic do_trig(input int addr, input bit exp);
    wr_g = b2g(addr); trig = 1'b1;
    tick(1);
    trig = 1'b0;
    model[addr] = exp;
  endtask

  task automatic pulse_trig(input bit use_test, input int dly, input int addr, input bit exp);
    if (use_test) tpulse = 1'b1; else hit = 1'b1;
    tick(1);
    hit = 1'b0; tpulse = 1'b0;
    tick(dly - 1);
    do_trig(addr, exp);
  endtask

  task automatic rd(input int addr, input string req);
    exp_t e;
    e.val = int'(model[addr]); e.req = req;
    sb_q.push_back(e);
    rd_g = b2g(addr); ro_load = 1'b1;
    tick(1);
    ro_load = 1'b0;
  endtask

  task automatic sh(input bit d, input string req);
    exp_t e;
    e.val = int'(d); e.req = req;
    sb_q.push_back(e);
    ro_din = d; ro_shift = 1'b1;
    tick(1);
    ro_shift = 1'b0;
  endtask

  task automatic cfg(input bit m, input bit t, input logic [2:0] th);
    cfg_mask = m; cfg_ten = t; cfg_th = th; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R13 reset state
    chk("R13_ovf", int'(ovf), 0);
    chk("R13_thadj", int'(thadj), 0);
    chk("R13_dout", int'(ro_dout), 0);
    rd(1, "R13_entry");

    // R9 config load and hold
    cfg(1'b0, 1'b0, 3'd5);
    chk("R9_load", int'(thadj), 5);
    cfg_th = 3'd2; cfg_mask = 1'b1;
    tick(2);
    chk("R9_hold", int'(thadj), 5);
    cfg_mask = 1'b0;

    // R2 exact-latency match, entry 0
    pulse_trig(1'b0, L, 0, 1'b1);
    rd(0, "R2_match");
    // R2 one cycle early: no match, entry 1
    pulse_trig(1'b0, L - 1, 1, 1'b0);
    rd(1, "R2_early");
    tick(4);

    // R4 expiry frees the holders: two hits fit without overflow
    hit = 1'b1; tick(2); hit = 1'b0;
    tick(1);
    chk("R4_freed", int'(ovf), 0);
    tick(L + 3);
    do_trig(3, 1'b0);
    rd(3, "R4_late_trig");

    // R5 two concurrent hits, each accepted by its own trigger
    hit = 1'b1; tick(1); hit = 1'b0; tick(4);
    hit = 1'b1; tick(1); hit = 1'b0;
    tick(L - 6);
    do_trig(2, 1'b1);
    tick(4);
    do_trig(3, 1'b1);
    rd(2, "R5_first");
    rd(3, "R5_second");

    // R3 release on match: two new hits fit
    hit = 1'b1; tick(2); hit = 1'b0;
    tick(1);
    chk("R3_release", int'(ovf), 0);
    tick(L + 3);

    // R7 mask suppresses hit and test pulse
    cfg(1'b1, 1'b1, 3'd5);
    pulse_trig(1'b0, L, 0, 1'b0);
    rd(0, "R7_mask_hit");
    model[2] = 1'b1;
    pulse_trig(1'b1, L, 2, 1'b0);
    rd(2, "R7_mask_test");

    // R8 test pulse gated by test enable
    cfg(1'b0, 1'b0, 3'd5);
    pulse_trig(1'b1, L, 3, 1'b0);
    rd(3, "R8_test_off");
    cfg(1'b0, 1'b1, 3'd5);
    pulse_trig(1'b1, L, 1, 1'b1);
    rd(1, "R8_test_on");

    // R12 wrap of the modulo-n timestamp during the wait
    while (ts_b != 8'(N - 5)) tick(1);
    pulse_trig(1'b0, L, 0, 1'b1);
    rd(0, "R12_wrap");

    // R10 gray pointer decode: gray 11 -> entry 2, gray 10 -> entry 3
    pulse_trig(1'b0, L, 2, 1'b1);
    rd(2, "R10_g11");
    rd(3, "R10_g10");

    // R11 load then serial shift chain
    rd(0, "R11_load");
    sh(1'b0, "R11_shift0");
    sh(1'b1, "R11_shift1");
    ro_load = 1'b1; ro_shift = 1'b1; ro_din = 1'b1; rd_g = b2g(3);
    begin
      exp_t e; e.val = int'(model[3]); e.req = "R11_load_wins";
      model[3] = 1'b0;
      e.val = 0;
      sb_q.push_back(e);
    end
    tick(1);
    ro_load = 1'b0; ro_shift = 1'b0;
    tick(1);

    // R6 overflow drop and stickiness
    hit = 1'b1; tick(3); hit = 1'b0;
    tick(1);
    chk("R6_drop", int'(ovf), 1);
    tick(L + 3);
    chk("R6_sticky", int'(ovf), 1);

    // R13 reset clears everything
    rst = 1'b1; tick(2); rst = 1'b0;
    tick(1);
    chk("R13_ovf_clr", int'(ovf), 0);
    chk("R13_thadj_clr", int'(thadj), 0);
    model = '{0, 0, 0, 0};
    rd(0, "R13_entry0");
    tick(2);

    if (sb_q.size() != 0) chk("SB_LEFT", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule